// File: doc/BRIEF.md
# PCI Memory Window Address Translator

This block turns an access that lands in one of three host-side memory windows into a 32-bit address on the PCI memory side. Each window has its own guest-writable map register that sets where the window starts in PCI memory. A second bank of three registers, the secondary map registers, is stored and read back but plays no part in translation. All six registers live in a 4 KiB control space that accepts only 32-bit accesses.

A variant input selects how a map register is read. In nibble mode, bits 3:0 of the map register become PCI address bits 31:28. In masked mode, the register is used as a base aligned to the window size. Each mode has its own set of window sizes. The offset within the window is cut to the window size and then added to the base. The translated address is combinational from the registers, so it follows a register write from the next cycle on.

Top module: `pciwin_xlate`

## Requirements
- R1: After reset all six registers read 0. The translated address is then 0 plus the window-limited offset.
- R2: Map registers for windows 0, 1 and 2 sit at byte offsets 0x00, 0x04 and 0x08. A 4-byte read returns all 32 bits last written. Read data appears on `reg_rdata` one cycle after the read strobe and holds until the next read.
- R3: Secondary registers at offsets 0x14, 0x18 and 0x1C read back what was written. Writing them leaves `pci_addr` unchanged.
- R4: With `mode_sized`=0, the window sizes are 0x0C000000, 0x10000000 and 0x10000000. The result is `pci_addr` = {map[3:0], 28'h0} + (win_off & (size-1)).
- R5: With `mode_sized`=1, the window sizes are 0x01000000, 0x04000000 and 0x08000000. The result is `pci_addr` = (map & ~(size-1)) + (win_off & (size-1)).
- R6: A map register write changes `pci_addr` from the cycle after the write edge.
- R7: A 4-byte access to any other offset, including unaligned ones, pulses `reg_err` high for one cycle after the strobe. Such a read returns 0, and no register changes.
- R8: An access whose `reg_size` is not 4 is ignored. No register changes, a read returns 0, and `reg_err` stays low.
- R9: `win_sel`=3 selects no window, and `pci_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset in the control space |
| reg_size | input | 3 | Access width in bytes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| reg_err | output | 1 | One-cycle pulse for an access to an undefined offset |
| mode_sized | input | 1 | 0: nibble map mode, 1: size-masked map mode |
| win_sel | input | 2 | Window index 0..2; 3 selects none |
| win_off | input | 32 | Offset of the access within the window |
| pci_addr | output | 32 | Translated PCI memory address |

## Verification
Some properties are checked on every cycle. In nibble mode the top four address bits must equal the map nibble. In masked mode the address bits above the window must equal the map bits. A 4-byte map write must land in its register. A wrongly sized access must leave every register unchanged. An error pulse must follow a 4-byte access. An idle select must give address zero. The exact sums, carry-free masking with the non-power-of-two 0x0C000000 window, read-back of both banks, reset values, and the silence of secondary writes on the translation are shown only by the bench's vectors and directed cases.

// File: rtl/pciwin_pkg.sv
package pciwin_pkg;
   typedef logic [31:0] word_t;

   // byte offsets of the two register banks
   localparam int MAP_BASE  = 'h000;
   localparam int SEC_BASE  = 'h014;
   localparam int STRIDE    = 4;
   localparam int ACC_BYTES = 4;

   // size mask for a window of the given byte size
   function automatic word_t win_mask(input word_t size);
      return size - 32'd1;
   endfunction
endpackage

// File: rtl/pciwin_regs.sv
module pciwin_regs
   import pciwin_pkg::*;
#(
   parameter int NUM_WIN = 3,
   parameter int ADDR_W  = 12
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      wr,
   input  logic                      rd,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [2:0]                size,
   input  word_t                     wdata,
   output word_t                     rdata,
   output logic                      err,
   output logic [NUM_WIN-1:0][31:0]  map_q
);
   localparam int SPAN = 1 << ADDR_W;

   if (NUM_WIN < 1 || NUM_WIN > (SEC_BASE - MAP_BASE) / STRIDE) begin : g_bad_num
      $error("pciwin_regs: NUM_WIN must let the two banks stay apart");
   end
   if (SEC_BASE + NUM_WIN * STRIDE > SPAN) begin : g_bad_span
      $error("pciwin_regs: banks do not fit the control space");
   end

   logic [NUM_WIN-1:0][31:0] sec_q;
   logic [NUM_WIN-1:0]       hit_map;
   logic [NUM_WIN-1:0]       hit_sec;
   logic                     size_ok;
   logic                     hit_any;
   word_t                    rd_mux;

   assign size_ok = (size == 3'(ACC_BYTES));

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NUM_WIN; i++) begin
         hit_map[i] = (addr == ADDR_W'(MAP_BASE + i * STRIDE));
         hit_sec[i] = (addr == ADDR_W'(SEC_BASE + i * STRIDE));
         if (hit_map[i]) rd_mux = map_q[i];
         if (hit_sec[i]) rd_mux = sec_q[i];
      end
      hit_any = |{hit_map, hit_sec};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         map_q <= '0;
         sec_q <= '0;
         rdata <= '0;
         err   <= 1'b0;
      end else begin
         err <= 1'b0;
         if ((wr || rd) && size_ok) begin
            err <= !hit_any;
            if (wr) begin
               for (int i = 0; i < NUM_WIN; i++) begin
                  if (hit_map[i]) map_q[i] <= wdata;
                  if (hit_sec[i]) sec_q[i] <= wdata;
               end
            end
            if (rd) rdata <= hit_any ? rd_mux : '0;
         end else if (rd) begin
            rdata <= '0;
         end
      end
   end

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_map_chk
      // R2
      map_wr_chk: assert property (@(posedge clk) disable iff (rst)
         (wr && size == 3'(ACC_BYTES) && addr == ADDR_W'(MAP_BASE + g * STRIDE))
         |=> map_q[g] == $past(wdata));
   end

   // R8
   size_ignore_chk: assert property (@(posedge clk) disable iff (rst)
      ((wr || rd) && size != 3'(ACC_BYTES))
      |=> ($stable(map_q) && $stable(sec_q) && !err));

   // R7
   err_cause_chk: assert property (@(posedge clk) disable iff (rst)
      err |-> $past((wr || rd) && size == 3'(ACC_BYTES)));
endmodule

// File: rtl/pciwin_lane.sv
module pciwin_lane
   import pciwin_pkg::*;
#(
   parameter word_t SIZE_NIB = 32'h1000_0000,
   parameter word_t SIZE_SZD = 32'h0100_0000
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  mode_sized,
   input  word_t map,
   input  word_t off,
   output word_t addr
);
   localparam word_t MASK_NIB = win_mask(SIZE_NIB);
   localparam word_t MASK_SZD = win_mask(SIZE_SZD);

   if (SIZE_NIB == 0 || SIZE_NIB > 32'h1000_0000) begin : g_bad_nib
      $error("pciwin_lane: nibble-mode window must be 1..256 MiB");
   end
   if (SIZE_SZD == 0 || (SIZE_SZD & MASK_SZD) != 0) begin : g_bad_szd
      $error("pciwin_lane: masked-mode window must be a power of two");
   end

   word_t base;
   word_t part;

   always_comb begin
      if (mode_sized) begin
         base = map & ~MASK_SZD;
         part = off & MASK_SZD;
      end else begin
         base = {map[3:0], 28'h0};
         part = off & MASK_NIB;
      end
      addr = base + part;
   end

   // R4
   nib_top_chk: assert property (@(posedge clk) disable iff (rst)
      !mode_sized |-> addr[31:28] == map[3:0]);

   // R5
   szd_base_chk: assert property (@(posedge clk) disable iff (rst)
      mode_sized |-> (addr & ~MASK_SZD) == (map & ~MASK_SZD));
endmodule

// File: rtl/pciwin_xlate.sv
module pciwin_xlate
   import pciwin_pkg::*;
#(
   parameter int                     NUM_WIN   = 3,
   parameter int                     ADDR_W    = 12,
   parameter int                     SEL_W     = $clog2(NUM_WIN + 1),
   parameter logic [NUM_WIN*32-1:0]  SIZES_NIB = {32'h1000_0000, 32'h1000_0000, 32'h0C00_0000},
   parameter logic [NUM_WIN*32-1:0]  SIZES_SZD = {32'h0800_0000, 32'h0400_0000, 32'h0100_0000}
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [2:0]        reg_size,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              reg_err,
   input  logic              mode_sized,
   input  logic [SEL_W-1:0]  win_sel,
   input  logic [31:0]       win_off,
   output logic [31:0]       pci_addr
);
   if ((1 << SEL_W) <= NUM_WIN) begin : g_bad_sel
      $error("pciwin_xlate: SEL_W too narrow for NUM_WIN");
   end

   logic [NUM_WIN-1:0][31:0] map_q;
   word_t                    lane_addr [NUM_WIN];

   pciwin_regs #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_regs (
      .clk   (clk),
      .rst   (rst),
      .wr    (reg_wr),
      .rd    (reg_rd),
      .addr  (reg_addr),
      .size  (reg_size),
      .wdata (reg_wdata),
      .rdata (reg_rdata),
      .err   (reg_err),
      .map_q (map_q)
   );

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_lane
      pciwin_lane #(
         .SIZE_NIB (SIZES_NIB[g*32 +: 32]),
         .SIZE_SZD (SIZES_SZD[g*32 +: 32])
      ) u_lane (
         .clk        (clk),
         .rst        (rst),
         .mode_sized (mode_sized),
         .map        (map_q[g]),
         .off        (win_off),
         .addr       (lane_addr[g])
      );
   end

   always_comb begin
      pci_addr = '0;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (win_sel == SEL_W'(i)) pci_addr = lane_addr[i];
      end
   end

   // R9
   sel_none_chk: assert property (@(posedge clk) disable iff (rst)
      (int'(win_sel) >= NUM_WIN) |-> pci_addr == '0);
endmodule

// File: tb/sim_pciwin_xlate.sv
module sim_pciwin_xlate;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [2:0]  reg_size = 3'd4;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        reg_err;
   logic        mode_sized = 1'b0;
   logic [1:0]  win_sel = '0;
   logic [31:0] win_off = '0;
   logic [31:0] pci_addr;

   int checks = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   pciwin_xlate u0 (.*);

   // {mode, sel, map, offset, expected}
   localparam logic [98:0] VEC [8] = '{
      {1'b0, 2'd0, 32'h0000_0003, 32'h0123_4567, 32'h3123_4567},
      {1'b0, 2'd1, 32'hFFFF_FFFA, 32'hDEAD_BEEF, 32'hAEAD_BEEF},
      {1'b0, 2'd2, 32'h0000_0005, 32'h1000_0010, 32'h5000_0010},
      {1'b0, 2'd0, 32'h0000_000F, 32'h0FFF_FFFF, 32'hFBFF_FFFF},
      {1'b1, 2'd0, 32'h1234_5678, 32'h00AB_CDEF, 32'h12AB_CDEF},
      {1'b1, 2'd1, 32'h8765_4321, 32'hFFFF_FFFF, 32'h87FF_FFFF},
      {1'b1, 2'd2, 32'hFFFF_FFFF, 32'h0000_0001, 32'hF800_0001},
      {1'b1, 2'd2, 32'h0800_0000, 32'h0800_0004, 32'h0800_0004}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [2:0] s);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_size = s;
      @(negedge clk);
      reg_wr = 1'b0; reg_size = 3'd4;
   endtask

   task automatic rd(input logic [11:0] a, input logic [2:0] s, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a; reg_size = s;
      @(negedge clk);
      reg_rd = 1'b0; reg_size = 3'd4;
      d = reg_rdata;
   endtask

   task automatic xl(input logic m, input logic [1:0] sel, input logic [31:0] off);
      mode_sized = m; win_sel = sel; win_off = off;
      #1;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=%h expected=%h", 32'h1, 32'h0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 1'b0;

      // R1 reset state
      for (int i = 0; i < 3; i++) begin
         rd(12'(4 * i), 3'd4, d);        chk("R1 map reset", d, 32'h0);
         rd(12'(20 + 4 * i), 3'd4, d);   chk("R1 sec reset", d, 32'h0);
      end
      xl(1'b0, 2'd1, 32'h1234_5678);
      chk("R1 reset translation", pci_addr, 32'h0234_5678);

      // R2 R4 R5 R6 vector table
      for (int v = 0; v < 8; v++) begin
         wr(12'(4 * int'(VEC[v][97:96])), VEC[v][95:64], 3'd4);
         xl(VEC[v][98], VEC[v][97:96], VEC[v][63:32]);
         chk(VEC[v][98] ? "R5 R6 masked mode" : "R4 R6 nibble mode", pci_addr, VEC[v][31:0]);
         rd(12'(4 * int'(VEC[v][97:96])), 3'd4, d);
         chk("R2 readback", d, VEC[v][95:64]);
      end

      // R3 secondary bank, no effect on translation
      wr(12'h000, 32'h0000_0002, 3'd4);
      xl(1'b0, 2'd0, 32'h0000_0100);
      wr(12'h014, 32'hCAFE_F00D, 3'd4);
      wr(12'h018, 32'h1111_2222, 3'd4);
      wr(12'h01C, 32'h9ABC_DEF0, 3'd4);
      chk("R3 translation unchanged", pci_addr, 32'h2000_0100);
      rd(12'h014, 3'd4, d); chk("R3 sec0 readback", d, 32'hCAFE_F00D);
      rd(12'h01C, 3'd4, d); chk("R3 sec2 readback", d, 32'h9ABC_DEF0);

      // R7 undefined offsets
      wr(12'h00C, 32'hFFFF_FFFF, 3'd4);
      chk("R7 err on bad write", {31'h0, reg_err}, 32'h1);
      @(negedge clk);
      chk("R7 err one cycle", {31'h0, reg_err}, 32'h0);
      rd(12'h002, 3'd4, d);
      chk("R7 bad read data", d, 32'h0);
      chk("R7 err on unaligned read", {31'h0, reg_err}, 32'h1);
      rd(12'h000, 3'd4, d);
      chk("R7 map0 untouched", d, 32'h0000_0002);

      // R8 wrong access size
      wr(12'h000, 32'h0000_0007, 3'd2);
      chk("R8 no err", {31'h0, reg_err}, 32'h0);
      chk("R8 translation unchanged", pci_addr, 32'h2000_0100);
      rd(12'h000, 3'd1, d);
      chk("R8 read returns 0", d, 32'h0);
      rd(12'h000, 3'd4, d);
      chk("R8 map0 unchanged", d, 32'h0000_0002);

      // R9 idle select
      xl(1'b1, 2'd3, 32'hFFFF_FFFF);
      chk("R9 no window", pci_addr, 32'h0);
      xl(1'b0, 2'd3, 32'h0000_0040);
      chk("R9 no window nibble", pci_addr, 32'h0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule